// File: doc/BRIEF.md
# Register-Write Command Stream Decoder

This block takes a byte stream, such as the payload of a bulk transfer, over a valid/ready byte interface. It splits the stream into commands. Every command opens with the prefix byte 0xAF and then an opcode byte. A register-write command stores an 8-bit value at an 8-bit address in a small register file. A copy command is parsed, and its source address, pixel count and destination address appear on a separate output together with a one-cycle strobe. Bytes that do not form a known command are thrown away, and the parser waits for the next prefix.

Address 0xFF is a control location and holds no data. Writing 0x00 there locks the video registers. While they are locked, writes land only in shadow storage. Writing 0xFF there unlocks them, and every shadow value is copied into the active registers on one clock edge. While the registers are unlocked, a write updates the shadow and active copies together. Several fields are decoded from the active registers. Most multi-byte fields put the most significant byte at the lowest address. The pixel-clock field is the exception: it puts its low byte first.

Back-pressure: `in_ready` is low during reset and high from the first clock edge after reset is released. A byte is consumed on every rising edge where `in_valid` and `in_ready` are both high. The parser never stalls, so `in_data` is taken only on those edges.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After reset, every active register reads 0, `vid_locked` is low, `cp_strobe` is low, and `in_ready` is low while `rst_n` is low and high from the first edge after release.
- R2: The sequence 0xAF, 0x20, addr, val with the registers unlocked and addr below 0x40 (REG_COUNT) makes `rd_data` at `rd_addr`=addr show val right after the edge that accepts val.
- R3: Writing 0x00 to address 0xFF raises `vid_locked`. While it is high, register writes leave every active register unchanged.
- R4: Writing 0xFF to address 0xFF copies all shadow registers into the active registers on that edge and lowers `vid_locked`.
- R5: Any other value written to address 0xFF changes nothing, and `rd_data` at address 0xFF always reads 0.
- R6: A write to an address from 0x40 up to 0xFE is dropped, and those addresses read 0.
- R7: Resynchronisation covers three cases. A byte other than 0xAF outside a command is discarded. An unknown opcode ends the command, and the following bytes are discarded until the next 0xAF. A 0xAF in the opcode position starts a new command.
- R8: The sequence 0xAF, 0x6A is followed by 3 source-address bytes (most significant first), 1 count byte and 3 destination-address bytes (most significant first). `cp_strobe` is high for exactly the one cycle after the ninth byte, with `cp_src`, `cp_count` and `cp_dst` valid.
- R9: The following fields are most significant byte first: `base16` = {reg 0x20, 0x21, 0x22}, `base8` = {0x26, 0x27, 0x28}, `h_active` = {0x0F, 0x10}, `v_active` = {0x17, 0x18}.
- R10: `pix_clk` = {reg 0x1C, reg 0x1B}, so the low byte sits at the lower address. `deep_color` is bit 0 of reg 0x00, where 1 means 24 bpp and 0 means 16 bpp.
- R11: No byte is consumed in a cycle where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Decoder can take a byte |
| rd_addr | input | 8 | Active register read address |
| rd_data | output | 8 | Active register contents (combinational) |
| vid_locked | output | 1 | Video registers locked |
| deep_color | output | 1 | Colour depth select (1 = 24 bpp) |
| base16 | output | 24 | Base pointer of the 16 bpp plane |
| base8 | output | 24 | Base pointer of the 8 bpp plane |
| h_active | output | 16 | Active pixels per line |
| v_active | output | 16 | Active lines |
| pix_clk | output | 16 | Pixel clock in 5 kHz units |
| cp_strobe | output | 1 | Copy command decoded |
| cp_src | output | 24 | Copy source address |
| cp_count | output | 8 | Copy pixel count |
| cp_dst | output | 24 | Copy destination address |

## Verification
The effect of a register write and of a lock or unlock is due on the same edge that accepts the final byte of its command. `rd_data` and the decoded fields are combinational reads of the active registers. The bench drives each byte on a falling edge and samples one time unit after the rising edge that accepts it. `cp_strobe` is registered, so the bench samples it just after the edge that accepts the ninth copy byte, and again one edge later to confirm it has dropped.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam logic [7:0] PREFIX_BYTE = 8'hAF;
  localparam logic [7:0] OP_REG_WR   = 8'h20;
  localparam logic [7:0] OP_COPY     = 8'h6A;
  localparam logic [7:0] CTRL_ADDR   = 8'hFF;
  localparam logic [7:0] LOCK_VAL    = 8'h00;
  localparam logic [7:0] UNLOCK_VAL  = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPC,
    S_WADDR,
    S_WVAL,
    S_COPY
  } pstate_t;
endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic [7:0]              in_data,
  output logic                    wr_en,
  output logic [7:0]              wr_addr,
  output logic [7:0]              wr_data,
  output logic                    cp_strobe,
  output logic [ADDR_BYTES*8-1:0] cp_src,
  output logic [7:0]              cp_count,
  output logic [ADDR_BYTES*8-1:0] cp_dst
);
  localparam int AW    = ADDR_BYTES * 8;
  localparam int NARGS = 2 * ADDR_BYTES + 1;
  localparam int SHW   = NARGS * 8;
  localparam int CNTW  = $clog2(NARGS + 1);

  pstate_t         st_q;
  logic [CNTW-1:0] cnt_q;
  logic [7:0]      addr_q;
  logic [SHW-1:0]  sh_q;
  logic [SHW-1:0]  sh_nxt;
  logic            last_arg;

  assign sh_nxt   = {sh_q[SHW-9:0], in_data};
  assign last_arg = (cnt_q == CNTW'(NARGS - 1));

  assign wr_en   = beat && (st_q == S_WVAL);
  assign wr_addr = addr_q;
  assign wr_data = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      addr_q    <= '0;
      sh_q      <= '0;
      cp_strobe <= 1'b0;
      cp_src    <= '0;
      cp_count  <= '0;
      cp_dst    <= '0;
    end else begin
      cp_strobe <= 1'b0;
      if (beat) begin
        unique case (st_q)
          S_IDLE:  if (in_data == PREFIX_BYTE) st_q <= S_OPC;
          S_OPC: begin
            if (in_data == OP_REG_WR) st_q <= S_WADDR;
            else if (in_data == OP_COPY) begin
              st_q  <= S_COPY;
              cnt_q <= '0;
            end else if (in_data == PREFIX_BYTE) st_q <= S_OPC;
            else st_q <= S_IDLE;
          end
          S_WADDR: begin
            addr_q <= in_data;
            st_q   <= S_WVAL;
          end
          S_WVAL:  st_q <= S_IDLE;
          S_COPY: begin
            sh_q  <= sh_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (last_arg) begin
              st_q      <= S_IDLE;
              cp_strobe <= 1'b1;
              cp_src    <= sh_nxt[SHW-1 -: AW];
              cp_count  <= sh_nxt[AW +: 8];
              cp_dst    <= sh_nxt[AW-1:0];
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_strobe |=> !cp_strobe);

  // R7
  idle_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && st_q == S_IDLE && in_data != PREFIX_BYTE) |=> (st_q == S_IDLE));

  // R11
  no_beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(st_q));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import cmd_dec_pkg::*;
#(
  parameter int REG_COUNT = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [7:0]                   wr_addr,
  input  logic [7:0]                   wr_data,
  output logic                         locked,
  output logic [REG_COUNT-1:0][7:0]    active
);
  localparam int IDXW = $clog2(REG_COUNT);

  logic [REG_COUNT-1:0][7:0] shadow_q;
  logic [REG_COUNT-1:0][7:0] active_q;
  logic                      locked_q;
  logic                      is_ctrl;
  logic                      in_rng;
  logic                      do_unlock;
  logic [IDXW-1:0]           widx;

  assign is_ctrl   = (wr_addr == CTRL_ADDR);
  assign in_rng    = ({1'b0, wr_addr} < 9'(REG_COUNT)) && !is_ctrl;
  assign do_unlock = wr_en && is_ctrl && (wr_data == UNLOCK_VAL);
  assign widx      = wr_addr[IDXW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) locked_q <= 1'b0;
    else if (wr_en && is_ctrl) begin
      if (wr_data == LOCK_VAL)        locked_q <= 1'b1;
      else if (wr_data == UNLOCK_VAL) locked_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && in_rng && (widx == IDXW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[g] <= '0;
        active_q[g] <= '0;
      end else begin
        if (hit) shadow_q[g] <= wr_data;
        if (do_unlock)             active_q[g] <= shadow_q[g];
        else if (hit && !locked_q) active_q[g] <= wr_data;
      end
    end
  end

  assign locked = locked_q;
  assign active = active_q;

  // R2
  unlocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_rng && !locked_q) |=> (active_q[$past(widx)] == $past(wr_data)));

  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked_q && !is_ctrl) |=> $stable(active_q));

  // R4
  unlock_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_unlock |=> ((active_q == $past(shadow_q)) && !locked_q));

  // R6
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_rng && !is_ctrl) |=> $stable(active_q));
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cmd_dec_pkg::*;
#(
  parameter int REG_COUNT  = 64,
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  output logic                    in_ready,
  input  logic [7:0]              rd_addr,
  output logic [7:0]              rd_data,
  output logic                    vid_locked,
  output logic                    deep_color,
  output logic [23:0]             base16,
  output logic [23:0]             base8,
  output logic [15:0]             h_active,
  output logic [15:0]             v_active,
  output logic [15:0]             pix_clk,
  output logic                    cp_strobe,
  output logic [ADDR_BYTES*8-1:0] cp_src,
  output logic [7:0]              cp_count,
  output logic [ADDR_BYTES*8-1:0] cp_dst
);
  localparam int IDXW     = $clog2(REG_COUNT);
  localparam int R_DEPTH  = 'h00;
  localparam int R_HACT   = 'h0F;
  localparam int R_VACT   = 'h17;
  localparam int R_PCLK   = 'h1B;
  localparam int R_BASE16 = 'h20;
  localparam int R_BASE8  = 'h26;

  logic                      ready_q;
  logic                      beat;
  logic                      wr_en;
  logic [7:0]                wr_addr;
  logic [7:0]                wr_data;
  logic [REG_COUNT-1:0][7:0] active;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign beat     = in_valid && ready_q;

  cmd_parser #(.ADDR_BYTES(ADDR_BYTES)) u_parser (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .in_data  (in_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cp_strobe(cp_strobe),
    .cp_src   (cp_src),
    .cp_count (cp_count),
    .cp_dst   (cp_dst)
  );

  reg_bank #(.REG_COUNT(REG_COUNT)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .locked (vid_locked),
    .active (active)
  );

  assign rd_data = ({1'b0, rd_addr} < 9'(REG_COUNT) && rd_addr != CTRL_ADDR)
                   ? active[rd_addr[IDXW-1:0]] : 8'h00;

  assign deep_color = active[R_DEPTH][0];
  assign base16     = {active[R_BASE16], active[R_BASE16+1], active[R_BASE16+2]};
  assign base8      = {active[R_BASE8], active[R_BASE8+1], active[R_BASE8+2]};
  assign h_active   = {active[R_HACT], active[R_HACT+1]};
  assign v_active   = {active[R_VACT], active[R_VACT+1]};
  assign pix_clk    = {active[R_PCLK+1], active[R_PCLK]};

  // R5
  ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == CTRL_ADDR) |-> (rd_data == 8'h00));
endmodule

// File: tb/test_cmd_stream_decoder.sv
`timescale 1ns/1ps
module test_cmd_stream_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic [7:0]  rd_addr = 8'h00;
  logic [7:0]  rd_data;
  logic        vid_locked, deep_color, cp_strobe;
  logic [23:0] base16, base8, cp_src, cp_dst;
  logic [15:0] h_active, v_active, pix_clk;
  logic [7:0]  cp_count;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cmd_stream_decoder i_cmd_stream_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .vid_locked(vid_locked), .deep_color(deep_color), .base16(base16),
    .base8(base8), .h_active(h_active), .v_active(v_active), .pix_clk(pix_clk),
    .cp_strobe(cp_strobe), .cp_src(cp_src), .cp_count(cp_count), .cp_dst(cp_dst)
  );

  // {stream byte, read address, expected rd_data after the accepting edge}
  localparam int NV = 27;
  localparam logic [23:0] VEC [NV] = '{
    24'hAF_05_00, 24'h20_05_00, 24'h05_05_00, 24'h3C_05_3C,  // R2
    24'h55_05_3C,                                            // R7
    24'hAF_05_3C, 24'h20_05_3C, 24'hFF_05_3C, 24'h00_05_3C,  // R3 lock
    24'hAF_05_3C, 24'h20_05_3C, 24'h05_05_3C, 24'h77_05_3C,  // R3 shadow only
    24'hAF_05_3C, 24'h20_05_3C, 24'hFF_05_3C, 24'hFF_05_77,  // R4 commit
    24'hAF_05_77, 24'h13_05_77, 24'h20_05_77, 24'h05_05_77,
    24'h99_05_77,                                            // R7 unknown opcode
    24'hAF_06_00, 24'hAF_06_00, 24'h20_06_00, 24'h06_06_00,
    24'h11_06_11                                             // R7 double prefix
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    send(8'hAF); send(8'h20); send(a); send(v);
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 ready in reset", {31'h0, in_ready}, 32'h0);
    check("R1 locked", {31'h0, vid_locked}, 32'h0);
    check("R1 strobe", {31'h0, cp_strobe}, 32'h0);
    check("R1 base16", {8'h0, base16}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 ready after reset", {31'h0, in_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rd_addr  = VEC[i][15:8];
      in_valid = 1'b1;
      in_data  = VEC[i][23:16];
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      check($sformatf("R2/R3/R4/R7 vector %0d", i), {24'h0, rd_data}, {24'h0, VEC[i][7:0]});
    end

    // R5: other values at the control address
    wr(8'hFF, 8'h42);
    check("R5 stray ctrl value unlocked", {31'h0, vid_locked}, 32'h0);
    wr(8'hFF, 8'h00);
    check("R3 locked flag", {31'h0, vid_locked}, 32'h1);
    wr(8'hFF, 8'h42);
    check("R5 stray ctrl value locked", {31'h0, vid_locked}, 32'h1);
    wr(8'hFF, 8'hFF);
    check("R4 unlocked flag", {31'h0, vid_locked}, 32'h0);
    rd_check("R5 ctrl reads zero", 8'hFF, 8'h00);

    // R6
    wr(8'h40, 8'hAA);
    rd_check("R6 out of range", 8'h40, 8'h00);
    wr(8'h3F, 8'h5B);
    rd_check("R6 top in range", 8'h3F, 8'h5B);

    // R9 / R10 field byte order, written under lock
    wr(8'hFF, 8'h00);
    wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
    wr(8'h26, 8'h01); wr(8'h27, 8'h2C); wr(8'h28, 8'h00);
    wr(8'h0F, 8'h05); wr(8'h10, 8'h00);
    wr(8'h17, 8'h02); wr(8'h18, 8'hD0);
    wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
    wr(8'h00, 8'h01);
    check("R3 fields held while locked", {8'h0, base16}, 32'h0);
    wr(8'hFF, 8'hFF);
    check("R9 base16", {8'h0, base16}, 32'h123456);
    check("R9 base8", {8'h0, base8}, 32'h012C00);
    check("R9 h_active", {16'h0, h_active}, 32'h0500);
    check("R9 v_active", {16'h0, v_active}, 32'h02D0);
    check("R10 pix_clk", {16'h0, pix_clk}, 32'h1234);
    check("R10 deep_color", {31'h0, deep_color}, 32'h1);

    // R8 copy command
    send(8'hAF); send(8'h6A);
    send(8'hA1); send(8'hB2); send(8'hC3);
    send(8'h07);
    send(8'hD4); send(8'hE5);
    check("R8 no early strobe", {31'h0, cp_strobe}, 32'h0);
    send(8'hF6);
    check("R8 strobe", {31'h0, cp_strobe}, 32'h1);
    check("R8 src", {8'h0, cp_src}, 32'hA1B2C3);
    check("R8 count", {24'h0, cp_count}, 32'h07);
    check("R8 dst", {8'h0, cp_dst}, 32'hD4E5F6);
    @(posedge clk);
    #1;
    check("R8 strobe one cycle", {31'h0, cp_strobe}, 32'h0);

    // R11: an idle cycle carrying an opcode-like byte is not consumed
    send(8'hAF);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'h6A;
    @(posedge clk);
    send(8'h20); send(8'h07); send(8'h5A);
    rd_check("R11 idle byte ignored", 8'h07, 8'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule